// File: doc/BRIEF.md
# Stereo Volume Slew Attenuator

This block scales a stereo stream of signed audio samples by a per-channel volume code and mutes it. One sample pair arrives per frame with a single-cycle frame strobe. Each channel holds its own current volume register, which never jumps. On every frame it moves one code toward a target, so level changes reach the output as a gradual ramp and do not click.

The target is the requested volume for that channel. While mute is active, the target becomes code 0 for both channels. Mute is active when either the mute pin or the mute register bit is high. Mute therefore uses the same ramp as a volume change. When it is released, each channel climbs back to its request. Gain is linear: a code of `v` multiplies the sample by `(v+1)/1024`, so the top code passes the sample unchanged. The scaled pair is registered and comes out with a valid strobe one cycle after the frame strobe.

Top module: `stereo_vol_ramp`

## Requirements
- R1: After reset, both current volume codes are 0x3FF (full scale), `valid_o` is low and both outputs are zero. With requests at 0x3FF, the first frame's samples come out unchanged.
- R2: On a frame, each output is `floor(sample * (v+1) / 1024)`, where `v` is that channel's current code before the frame's update. The result is saturated to the sample width.
- R3: On each frame, a channel's current code moves exactly one step toward its target when the two differ, and stays put when they are equal.
- R4: Current codes and outputs change only on cycles where `frame_i` is high. Request, mute and sample changes between frames have no effect on the outputs.
- R5: Mute is active when `mute_pin_i` or `mute_reg_i` is high. While it is active, the target of both channels is code 0 and the codes never rise.
- R6: When mute is released, each channel ramps back up to its own stored request, one code per frame.
- R7: When mute is active and a channel's code is 0, that channel's output on the frame is exactly zero. Without mute, code 0 gives `floor(sample/1024)`.
- R8: The two channels keep separate codes. A ramp on one channel leaves the other channel's gain unchanged.
- R9: `valid_o` is high for exactly the cycle after each frame strobe and low otherwise. The outputs hold between frames.
- R10: Starting from code 0x3FF with target 0, the 1023rd frame is scaled by code 1 and the 1024th frame by code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | One-cycle strobe per stereo frame |
| left_i | input | SAMPLE_W | Left sample, two's complement |
| right_i | input | SAMPLE_W | Right sample, two's complement |
| vol_l_i | input | VOL_W | Left requested volume code |
| vol_r_i | input | VOL_W | Right requested volume code |
| mute_pin_i | input | 1 | Hardware mute request |
| mute_reg_i | input | 1 | Register mute request |
| left_o | output | SAMPLE_W | Scaled left sample |
| right_o | output | SAMPLE_W | Scaled right sample |
| valid_o | output | 1 | Output pair valid, one cycle after `frame_i` |

## Verification
The bench drives a full 1024-frame swing on one channel while the other stays at full scale. A design that applied the new code in the same frame would be off by one step at the 1023rd and 1024th frames. A design that shared one register between the channels would disturb the idle channel. Mute is entered from the pin and from the register bit and then released. This catches a design that cuts the output at once, fails to force zero at code 0, or forgets the stored request on release. It also drives negative samples at low gain, where a logical shift or rounding would differ from floor. Requests and samples are changed between strobes to expose any update outside a frame.

// File: rtl/vol_ramp_pkg.sv
package vol_ramp_pkg;
  localparam int unsigned NUM_CH = 2;
  typedef enum logic {CH_L = 1'b0, CH_R = 1'b1} ch_e;
endpackage

// File: rtl/vol_slew.sv
module vol_slew #(
  parameter int unsigned VOL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [VOL_W-1:0] target_i,
  output logic [VOL_W-1:0] cur_o
);
  localparam logic [VOL_W-1:0] VOL_FULL = {VOL_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_o <= VOL_FULL;
    end else if (step_i) begin
      if (cur_o < target_i)      cur_o <= cur_o + 1'b1;
      else if (cur_o > target_i) cur_o <= cur_o - 1'b1;
    end
  end
endmodule

// File: rtl/vol_gain.sv
module vol_gain #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned VOL_W    = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic                       force_zero_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic        [VOL_W-1:0]    vol_i,
  output logic signed [SAMPLE_W-1:0] sample_o
);
  localparam int unsigned PROD_W = SAMPLE_W + VOL_W + 2;
  localparam logic signed [PROD_W-1:0] S_MAX =
    {{(PROD_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] S_MIN =
    {{(PROD_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

  logic        [VOL_W:0]       gain_u;
  logic signed [VOL_W+1:0]     gain_s;
  logic signed [PROD_W-1:0]    prod;
  logic signed [PROD_W-1:0]    shifted;
  logic signed [SAMPLE_W-1:0]  sat;

  assign gain_u  = {1'b0, vol_i} + {{VOL_W{1'b0}}, 1'b1};
  assign gain_s  = $signed({1'b0, gain_u});
  assign prod    = sample_i * gain_s;
  assign shifted = prod >>> VOL_W;

  always_comb begin
    if (shifted > S_MAX)      sat = S_MAX[SAMPLE_W-1:0];
    else if (shifted < S_MIN) sat = S_MIN[SAMPLE_W-1:0];
    else                      sat = shifted[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sample_o <= '0;
    else if (load_i) sample_o <= force_zero_i ? '0 : sat;
  end
endmodule

// File: rtl/stereo_vol_ramp.sv
module stereo_vol_ramp
  import vol_ramp_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned VOL_W    = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       frame_i,
  input  logic signed [SAMPLE_W-1:0] left_i,
  input  logic signed [SAMPLE_W-1:0] right_i,
  input  logic        [VOL_W-1:0]    vol_l_i,
  input  logic        [VOL_W-1:0]    vol_r_i,
  input  logic                       mute_pin_i,
  input  logic                       mute_reg_i,
  output logic signed [SAMPLE_W-1:0] left_o,
  output logic signed [SAMPLE_W-1:0] right_o,
  output logic                       valid_o
);
  logic                       mute_w;
  logic signed [SAMPLE_W-1:0] samp_in  [NUM_CH];
  logic signed [SAMPLE_W-1:0] samp_out [NUM_CH];
  logic        [VOL_W-1:0]    req      [NUM_CH];
  logic        [VOL_W-1:0]    cur_vol  [NUM_CH];

  assign mute_w       = mute_pin_i | mute_reg_i;
  assign samp_in[CH_L] = left_i;
  assign samp_in[CH_R] = right_i;
  assign req[CH_L]     = vol_l_i;
  assign req[CH_R]     = vol_r_i;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [VOL_W-1:0] target;
    assign target = mute_w ? '0 : req[ch];

    vol_slew #(.VOL_W(VOL_W)) u_slew (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .step_i   (frame_i),
      .target_i (target),
      .cur_o    (cur_vol[ch])
    );

    // scale with the code held before this frame's step
    vol_gain #(.SAMPLE_W(SAMPLE_W), .VOL_W(VOL_W)) u_gain (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .load_i       (frame_i),
      .force_zero_i (mute_w && (cur_vol[ch] == '0)),
      .sample_i     (samp_in[ch]),
      .vol_i        (cur_vol[ch]),
      .sample_o     (samp_out[ch])
    );
  end

  assign left_o  = samp_out[CH_L];
  assign right_o = samp_out[CH_R];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= frame_i;
  end
endmodule

// File: rtl/stereo_vol_ramp_chk.sv
module stereo_vol_ramp_chk #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned VOL_W    = 10
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                frame_i,
  input logic [VOL_W-1:0]    vol_l_i,
  input logic                mute_pin_i,
  input logic                mute_reg_i,
  input logic [SAMPLE_W-1:0] left_o,
  input logic                valid_o,
  input logic [VOL_W-1:0]    cur_l_i,
  input logic [VOL_W-1:0]    cur_r_i
);
  logic             mute_c;
  logic [VOL_W-1:0] tgt_l;
  assign mute_c = mute_pin_i | mute_reg_i;
  assign tgt_l  = mute_c ? '0 : vol_l_i;

  assert_hold_l_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(cur_l_i));
  assert_hold_r_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(cur_r_i));
  assert_step_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && cur_l_i < tgt_l) |=> ({1'b0, cur_l_i} == {1'b0, $past(cur_l_i)} + 1'b1));
  assert_step_dn_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && cur_l_i > tgt_l) |=> ({1'b0, cur_l_i} + 1'b1 == {1'b0, $past(cur_l_i)}));
  assert_no_rise_mute_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && mute_c) |=> (cur_r_i <= $past(cur_r_i)));
  assert_zero_out_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && mute_c && cur_l_i == '0) |=> (left_o == '0));
  assert_valid_hi_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> valid_o);
  assert_valid_lo_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> !valid_o);
endmodule

bind stereo_vol_ramp stereo_vol_ramp_chk #(.SAMPLE_W(SAMPLE_W), .VOL_W(VOL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_i    (frame_i),
  .vol_l_i    (vol_l_i),
  .mute_pin_i (mute_pin_i),
  .mute_reg_i (mute_reg_i),
  .left_o     (left_o),
  .valid_o    (valid_o),
  .cur_l_i    (cur_vol[0]),
  .cur_r_i    (cur_vol[1])
);

// File: tb/stereo_vol_ramp_test.sv
module stereo_vol_ramp_test;
  localparam int SW = 24;
  localparam int VW = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_i = 1'b0;
  logic signed [SW-1:0] left_i = '0, right_i = '0;
  logic [VW-1:0] vol_l_i = 10'h3FF, vol_r_i = 10'h3FF;
  logic mute_pin_i = 1'b0, mute_reg_i = 1'b0;
  logic signed [SW-1:0] left_o, right_o;
  logic valid_o;

  int checks = 0;
  int errors = 0;
  int cl = 1023, cr = 1023;
  int frames_done = 0;

  always #4 clk = ~clk;

  stereo_vol_ramp #(.SAMPLE_W(SW), .VOL_W(VW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_i(frame_i),
    .left_i(left_i), .right_i(right_i), .vol_l_i(vol_l_i), .vol_r_i(vol_r_i),
    .mute_pin_i(mute_pin_i), .mute_reg_i(mute_reg_i),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o));

  function automatic longint scale(input longint s, input int cur, input bit mute);
    longint p;
    if (mute && cur == 0) return 0;
    p = s * (cur + 1);
    return p >>> 10;
  endfunction

  function automatic int step(input int cur, input int tgt);
    if (cur < tgt) return cur + 1;
    if (cur > tgt) return cur - 1;
    return cur;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frame(input longint sl, input longint sr, input string rl, input string rr);
    bit m;
    longint el, er;
    @(negedge clk);
    left_i = SW'(sl); right_i = SW'(sr); frame_i = 1'b1;
    m = mute_pin_i | mute_reg_i;
    el = scale(sl, cl, m);
    er = scale(sr, cr, m);
    cl = step(cl, m ? 0 : int'(vol_l_i));
    cr = step(cr, m ? 0 : int'(vol_r_i));
    @(negedge clk);
    frame_i = 1'b0;
    check("R9", longint'(valid_o), 1);
    check(rl, longint'(left_o), el);
    check(rr, longint'(right_o), er);
    frames_done++;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint hl, hr;
    void'($urandom(32'd2024));
    idle(3);
    check("R1", longint'(valid_o), 0);
    check("R1", longint'(left_o), 0);
    check("R1", longint'(right_o), 0);
    rst_ni = 1'b1;
    idle(2);
    frame(64'sh123456, -64'sh300000, "R1", "R1");

    // R4: between-frame changes leave outputs alone
    hl = longint'(left_o); hr = longint'(right_o);
    @(negedge clk);
    left_i = 24'h0F0F0F; vol_l_i = 10'h000; mute_pin_i = 1'b1;
    idle(3);
    check("R9", longint'(valid_o), 0);
    check("R4", longint'(left_o), hl);
    check("R4", longint'(right_o), hr);
    mute_pin_i = 1'b0;

    // R10/R8: full swing on left, right held at full scale
    vol_l_i = 10'h000; vol_r_i = 10'h3FF;
    for (int i = 1; i <= 1024; i++) begin
      frame(64'sh7FFFFF, 64'sh400000, "R3", "R8");
      if (i == 1023) check("R10", longint'(left_o), 16383);
      if (i == 1024) check("R10", longint'(left_o), 8191);
    end
    check("R8", longint'(right_o), 64'sh400000);
    frame(-1, -64'sh7FF, "R2", "R2");
    check("R7", longint'(left_o), -1);

    // R5/R7: mute pin ramps both to zero and forces zero
    vol_l_i = 10'h200;
    for (int i = 0; i < 520; i++) frame(longint'($signed(24'($urandom))), 64'sh3ABCDE, "R3", "R2");
    mute_pin_i = 1'b1;
    for (int i = 0; i < 1025; i++) frame(64'sh5A5A5A, -64'sh654321, "R5", "R5");
    check("R7", longint'(left_o), 0);
    check("R7", longint'(right_o), 0);
    // R6: release, climb back to stored requests
    mute_pin_i = 1'b0;
    for (int i = 0; i < 1030; i++) frame(64'sh7FFFFF, -64'sh800000, "R6", "R6");
    check("R6", longint'(left_o), (64'sh7FFFFF * 513) >>> 10);
    check("R6", longint'(right_o), -64'sh800000);
    // R5: register bit mutes as well
    mute_reg_i = 1'b1;
    for (int i = 0; i < 40; i++) frame(64'sh7FFFFF, 64'sh7FFFFF, "R5", "R5");
    check("R5", longint'(right_o), (64'sh7FFFFF * (1024 - 39)) >>> 10);
    mute_reg_i = 1'b0;

    // random mix
    for (int i = 0; i < 500; i++) begin
      if ($urandom_range(0, 15) == 0) vol_l_i = VW'($urandom);
      if ($urandom_range(0, 15) == 0) vol_r_i = VW'($urandom);
      if ($urandom_range(0, 31) == 0) mute_pin_i = ~mute_pin_i;
      if ($urandom_range(0, 31) == 0) mute_reg_i = ~mute_reg_i;
      frame(longint'($signed(24'($urandom))), longint'($signed(24'($urandom))), "R2", "R2");
      idle($urandom_range(0, 3));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule